// File: doc/BRIEF.md
# Three-Wire Serial Register Loader

This block takes configuration frames from a three-wire serial port: a latch strobe, a serial clock and a data line. While the latch line is low, each rising edge of the serial clock shifts one data bit into a 17-bit frame, first bit first. When the latch line rises, the frame is committed, but only if at least 17 bits arrived during that low period. The frame carries three things. The first is a test bit that must be zero. The second is a clock-source select bit. The third is a 5-bit register address followed by a 10-bit value.

Addresses 0 to 11 hold the twelve channel codes that drive the output levels. Address 12 is a control register. Writing the value 0x2A0 to it raises a force flag, which makes the channels follow their codes whatever the external select pin says. Writing any other value to it lowers the flag.

All three serial inputs are resynchronised into the system clock domain and edge-detected there. The system clock must therefore run at least four times faster than the serial clock. The port is write-only and carries no stream handshake. Outputs hold their values between commits.

Top module: `sreg_loader`

## Requirements
- R1: Data bits are taken on rising edges of the serial clock only while the synchronised latch is low. The first bit taken becomes frame bit d0. A serial clock edge that is seen in the same system cycle as the latch rising edge is not taken.
- R2: Outputs change only on a committed latch rising edge. Shifting bits without a latch rise leaves every output unchanged.
- R3: If fewer than 17 bits were taken during the low latch period, the latch rise changes nothing.
- R4: If more than 17 bits were taken, only the 17 most recent form the frame.
- R5: The address is d2..d6, with d2 as the MSB. The value is d7..d16, with d7 as the MSB. A committed frame with address n, where n is from 0 to 11, loads the value into channel code n, which sits at bits [10n+9:10n] of `chan_code`. No other channel changes.
- R6: After reset, all channel codes are 0x000, `osc_ext` is 0 and `dac_force` is 0.
- R7: A committed frame with d0 = 0 copies d1 to `osc_ext`, where 1 selects the external clock source.
- R8: A frame with d0 = 1 changes no output at all.
- R9: Addresses 13 to 31 change no channel code and no force flag. `osc_ext` is still updated by R7.
- R10: A committed write to address 12 sets `dac_force` to 1 when the value is 0x2A0 and to 0 for any other value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock rate |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| ser_clk | input | 1 | Serial shift clock |
| ser_latch | input | 1 | Latch strobe; low while a frame is shifted, rising edge commits |
| ser_din | input | 1 | Serial data, d0 first |
| chan_code | output | 120 | Twelve 10-bit channel codes, channel n at [10n+9:10n] |
| osc_ext | output | 1 | Clock-source select: 0 internal, 1 external |
| dac_force | output | 1 | Channels follow their codes regardless of the select pin |

## Verification
Two functions can land on the same system cycle. One is a serial clock rising edge. The other is the latch rising edge that commits the frame. The bench shifts a full 17-bit frame, places an 18th bit on the data line, and then raises the serial clock and the latch together. Both edges therefore pass through the synchronisers in step. The bench then checks that the committed code equals the 17-bit frame without the 18th bit, which shows that the coinciding edge was not taken as a shift.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
  localparam int CHAN_N    = 12;
  localparam int CODE_W    = 10;
  localparam int ADDR_W    = 5;
  localparam int FRAME_W   = 2 + ADDR_W + CODE_W;
  localparam int CNT_W     = $clog2(FRAME_W + 1);
  localparam int TEST_BIT  = FRAME_W - 1;
  localparam int OSC_BIT   = FRAME_W - 2;
  localparam int ADDR_LSB  = CODE_W;
  localparam int CTRL_ADDR = CHAN_N;
  localparam logic [CODE_W-1:0] MAGIC = 10'h2A0;

  typedef logic [FRAME_W-1:0] frame_t;
  typedef logic [CODE_W-1:0]  code_t;
  typedef logic [ADDR_W-1:0]  addr_t;
endpackage

// File: rtl/sreg_sync_edge.sv
module sreg_sync_edge #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out,
  output logic [W-1:0] rise
);
  logic [W-1:0] stage_q [STAGES];
  logic [W-1:0] prev_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= async_in;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= stage_q[s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= '0;
    else        prev_q <= stage_q[STAGES-1];

  assign sync_out = stage_q[STAGES-1];
  assign rise     = stage_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/sreg_frame_shifter.sv
module sreg_frame_shifter
  import sreg_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   shift_en,
  input  logic   bit_in,
  input  logic   clear,
  output frame_t frame,
  output logic   full
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame <= '0;
      cnt_q <= '0;
    end else if (clear) begin
      cnt_q <= '0;
    end else if (shift_en) begin
      frame <= {frame[FRAME_W-2:0], bit_in};
      if (cnt_q != CNT_W'(FRAME_W)) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign full = (cnt_q == CNT_W'(FRAME_W));
endmodule

// File: rtl/sreg_bank.sv
module sreg_bank
  import sreg_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     commit,
  input  frame_t                   frame,
  output logic [CHAN_N*CODE_W-1:0] chan_code,
  output logic                     osc_ext,
  output logic                     dac_force
);
  logic  test_b;
  addr_t addr;
  code_t data;
  logic  take;

  assign test_b = frame[TEST_BIT];
  assign addr   = frame[ADDR_LSB +: ADDR_W];
  assign data   = frame[CODE_W-1:0];
  assign take   = commit && !test_b;

  generate
    for (genvar i = 0; i < CHAN_N; i++) begin : g_chan
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)
          chan_code[i*CODE_W +: CODE_W] <= '0;
        else if (take && addr == ADDR_W'(i))
          chan_code[i*CODE_W +: CODE_W] <= data;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      osc_ext   <= 1'b0;
      dac_force <= 1'b0;
    end else if (take) begin
      osc_ext <= frame[OSC_BIT];
      if (addr == ADDR_W'(CTRL_ADDR)) dac_force <= (data == MAGIC);
    end
  end
endmodule

// File: rtl/sreg_loader.sv
module sreg_loader
  import sreg_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ser_clk,
  input  logic                     ser_latch,
  input  logic                     ser_din,
  output logic [CHAN_N*CODE_W-1:0] chan_code,
  output logic                     osc_ext,
  output logic                     dac_force
);
  logic [2:0] sync_v;
  logic [2:0] rise_v;
  logic       lat_rise;
  logic       sck_rise;
  logic       shift_en;
  logic       frame_full;
  frame_t     frame_q;

  sreg_sync_edge #(.W(3), .STAGES(2)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in ({ser_din, ser_latch, ser_clk}),
    .sync_out (sync_v),
    .rise     (rise_v)
  );

  assign sck_rise = rise_v[0];
  assign lat_rise = rise_v[1];
  assign shift_en = sck_rise && !sync_v[1];

  sreg_frame_shifter u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (shift_en),
    .bit_in   (sync_v[2]),
    .clear    (lat_rise),
    .frame    (frame_q),
    .full     (frame_full)
  );

  sreg_bank u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .commit    (lat_rise && frame_full),
    .frame     (frame_q),
    .chan_code (chan_code),
    .osc_ext   (osc_ext),
    .dac_force (dac_force)
  );
endmodule

// File: rtl/sreg_loader_chk.sv
module sreg_loader_chk
  import sreg_pkg::*;
(
  input logic                     clk,
  input logic                     rst_n,
  input logic                     lat_rise,
  input logic                     frame_full,
  input frame_t                   frame_q,
  input logic [CHAN_N*CODE_W-1:0] chan_code,
  input logic                     osc_ext,
  input logic                     dac_force
);
  addr_t fa;
  assign fa = frame_q[ADDR_LSB +: ADDR_W];

  a_r2_hold_without_latch: assert property (@(posedge clk) disable iff (!rst_n)
    !lat_rise |=> ($stable(chan_code) && $stable(osc_ext) && $stable(dac_force)));

  a_r3_short_frame_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_rise && !frame_full) |=> ($stable(chan_code) && $stable(osc_ext) && $stable(dac_force)));

  a_r8_test_bit_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_rise && frame_full && frame_q[TEST_BIT]) |=>
      ($stable(chan_code) && $stable(osc_ext) && $stable(dac_force)));

  a_r7_osc_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_rise && frame_full && !frame_q[TEST_BIT]) |=> (osc_ext == $past(frame_q[OSC_BIT])));

  a_r10_force_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_rise && frame_full && !frame_q[TEST_BIT] && fa == ADDR_W'(CTRL_ADDR)) |=>
      (dac_force == ($past(frame_q[CODE_W-1:0]) == MAGIC)));

  a_r9_high_addr_no_code: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_rise && frame_full && fa > ADDR_W'(CTRL_ADDR)) |=>
      ($stable(chan_code) && $stable(dac_force)));
endmodule

bind sreg_loader sreg_loader_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .lat_rise   (lat_rise),
  .frame_full (frame_full),
  .frame_q    (frame_q),
  .chan_code  (chan_code),
  .osc_ext    (osc_ext),
  .dac_force  (dac_force)
);

// File: tb/test_sreg_loader.sv
module test_sreg_loader;
  localparam int NCH = 12;
  localparam int CW  = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0;
  logic ser_latch = 1'b1;
  logic ser_din = 1'b0;
  logic [NCH*CW-1:0] chan_code;
  logic osc_ext;
  logic dac_force;

  int checks = 0;
  int errors = 0;
  logic [CW-1:0] exp_code [NCH];
  logic exp_osc = 1'b0;
  logic exp_force = 1'b0;

  always #4 clk = ~clk;

  sreg_loader i_sreg_loader (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_latch(ser_latch),
    .ser_din(ser_din), .chan_code(chan_code), .osc_ext(osc_ext), .dac_force(dac_force)
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    logic [NCH*CW-1:0] e;
    for (int i = 0; i < NCH; i++) e[i*CW +: CW] = exp_code[i];
    chk(req, 128'(chan_code), 128'(e));
    chk(req, 128'(osc_ext), 128'(exp_osc));
    chk(req, 128'(dac_force), 128'(exp_force));
  endtask

  task automatic shift_bits(input logic [63:0] bits, input int n);
    @(negedge clk); ser_latch = 1'b0;
    repeat (3) @(negedge clk);
    for (int k = n - 1; k >= 0; k--) begin
      ser_din = bits[k];
      repeat (4) @(negedge clk); ser_clk = 1'b1;
      repeat (4) @(negedge clk); ser_clk = 1'b0;
    end
  endtask

  task automatic latch_up();
    repeat (3) @(negedge clk); ser_latch = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  function automatic logic [16:0] mk(input logic t, input logic o, input int a, input int d);
    return {t, o, 5'(a), 10'(d)};
  endfunction

  // expected effect of a committed 17-bit frame
  task automatic model(input logic [16:0] f);
    if (!f[16]) begin
      exp_osc = f[15];
      if (f[14:10] < 5'd12) exp_code[f[14:10]] = f[9:0];
      else if (f[14:10] == 5'd12) exp_force = (f[9:0] == 10'h2A0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [16:0] f;
    for (int i = 0; i < NCH; i++) exp_code[i] = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_all("R6 reset");

    // R5 R7 R9 R10: sweep every address with arithmetic values and alternating osc bit
    for (int a = 0; a < 32; a++) begin
      f = mk(1'b0, 1'(a % 2), a, (a * 53 + 17) % 1024);
      shift_bits(64'(f), 17); latch_up(); model(f);
      check_all(a < 12 ? "R5 channel write" : (a == 12 ? "R10 ctrl non-magic" : "R9 high address"));
    end

    // R10: magic sets, other clears
    f = mk(1'b0, 1'b1, 12, 10'h2A0);
    shift_bits(64'(f), 17); latch_up(); model(f);
    chk("R10 magic sets force", 128'(dac_force), 128'(1));
    f = mk(1'b0, 1'b0, 12, 10'h2A1);
    shift_bits(64'(f), 17); latch_up(); model(f);
    chk("R10 other value clears force", 128'(dac_force), 128'(0));
    f = mk(1'b0, 1'b1, 12, 10'h2A0);
    shift_bits(64'(f), 17); latch_up(); model(f);
    check_all("R10 force set again");

    // R8: test bit set, nothing changes (osc would flip, addr 3 would change)
    f = mk(1'b1, 1'b0, 3, 10'h155);
    shift_bits(64'(f), 17); latch_up();
    check_all("R8 test bit ignored");
    f = mk(1'b1, 1'b0, 12, 10'h000);
    shift_bits(64'(f), 17); latch_up();
    check_all("R8 test bit keeps force");

    // R3: short frames
    for (int n = 1; n <= 16; n++) begin
      f = mk(1'b0, 1'b0, 5, 10'h3FF);
      shift_bits(64'(f), n); latch_up();
      check_all("R3 short frame dropped");
    end

    // R2: outputs unchanged during shifting, then commit
    f = mk(1'b0, 1'b0, 7, 10'h0C3);
    shift_bits(64'(f), 17);
    repeat (10) @(negedge clk);
    check_all("R2 no change before latch");
    latch_up(); model(f);
    check_all("R2 commit on latch");

    // R4: extra leading bits are dropped
    for (int x = 1; x <= 5; x++) begin
      f = mk(1'b0, 1'(x % 2), x, 10'h200 + x * 7);
      shift_bits({47'h1F_FFFF_FFFF, f} & ((64'd1 << (17 + x)) - 1) | (64'h1 << 16) << x, 17 + x);
      latch_up(); model(f);
      check_all("R4 last 17 bits kept");
    end

    // R1: serial clock edge coinciding with latch rise is not taken
    f = mk(1'b0, 1'b1, 9, 10'h2B6);
    shift_bits(64'(f), 17);
    ser_din = 1'b1;
    repeat (4) @(negedge clk);
    ser_clk = 1'b1; ser_latch = 1'b1;
    repeat (8) @(negedge clk);
    ser_clk = 1'b0;
    repeat (4) @(negedge clk);
    model(f);
    check_all("R1 coincident edge not shifted");

    // R1: bit order, d0 first
    f = mk(1'b0, 1'b0, 0, 10'h001);
    shift_bits(64'(f), 17); latch_up(); model(f);
    check_all("R1 bit order");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule